// File: doc/BRIEF.md
# ASCII frequency command interpreter

This block turns a stream of received serial bytes into frequency settings for a synthesizer. It sits between a byte receiver and a byte transmitter. Commands are uppercase ASCII text closed by a carriage return. Decimal text, with an optional kilohertz or megahertz suffix, becomes a binary frequency in hertz. The block holds the current output frequency, a power-on default register and a 120-entry channel table, which is a plain register array.

Every accepted byte is echoed straight away. When a command is complete, the block answers with a prompt character or an error text. A read-all command lists the default and every channel as fixed-width decimal lines. Responses go out through a ready/valid byte handshake. There is no flow control towards the sender, so bytes that arrive while a response is going out are dropped.

Top module: `fcmd_ctrl`

## Requirements
- R1: After reset, freq_hz is 10,000,000, tx_valid is low, the default register holds 10,000,000 and every channel holds 0.
- R2: Every accepted byte, including the closing carriage return (0x0D), is sent back unchanged before any response byte. A valid command is then answered with a single '*' (0x2A).
- R3: A line of 1 to 9 decimal digits followed by CR sets freq_hz to that value in hertz. A tenth digit makes the line invalid.
- R4: Digits followed by 'K' set the value times 1,000. Digits followed by 'M' set the value times 1,000,000.
- R5: A resulting frequency below 1,000,000 or above 130,000,000, a lowercase letter, an unknown keyword, trailing text, a missing digit field or an empty line is invalid. An invalid line changes no state. It is answered with the twelve characters "INVALID DATA", then 0x0A, then 0x0D, then '*'.
- R6: "SAVE" followed by CR copies the current frequency into the default register and leaves freq_hz unchanged.
- R7: "SAVE", a space (0x20), a channel number of 1 to 3 digits, a space and frequency text in any unit form stores that frequency in the channel. A channel number above 119 is invalid, and the line then stores nothing.
- R8: "READ" followed by CR sends the default as 9 zero-padded decimal digits, then CR LF. It then sends channels 0 to 119 in ascending order, each as 3 channel digits, a space, 9 frequency digits, then CR LF. The dump ends with '*'.
- R9: While tx_valid is high and tx_ready is low, tx_valid and tx_data keep their values.
- R10: Bytes presented on rx_valid while a response is in progress are discarded. They are neither echoed nor parsed.
- R11: freq_hz changes only in the cycle after a carriage return is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter can take a byte this cycle |
| tx_valid | output | 1 | tx_data holds a byte to send |
| tx_data | output | 8 | Byte to send (echo or response) |
| freq_hz | output | 28 | Current output frequency in hertz |

## Verification
The hardest condition to reach from the ports is a byte that arrives in the middle of the long read-all dump while the transmitter is stalling at random. Only that case shows whether such bytes are dropped instead of echoed or parsed. The stimulus starts a dump and, partway through, sends a complete set command that would be valid. It checks that the dump continues byte for byte and that the frequency has not moved. A second dump runs with an irregular tx_ready pattern, so that the response sequencer and the held output byte face long stalls and ready toggling on every cycle.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    typedef enum logic [0:0] {ST_RX, ST_RESP} top_st_e;

    typedef enum logic [2:0] {
        PH_START, PH_KW, PH_KWEND, PH_CH, PH_NUM, PH_UNIT, PH_ERR
    } phase_e;

    typedef enum logic [1:0] {RSP_OK, RSP_BAD, RSP_READ} rsp_e;

    typedef enum logic [0:0] {KW_SAVE, KW_READ} kw_e;

    localparam logic [7:0] CH_CR   = 8'h0D;
    localparam logic [7:0] CH_LF   = 8'h0A;
    localparam logic [7:0] CH_SP   = 8'h20;
    localparam logic [7:0] CH_STAR = 8'h2A;

    function automatic logic is_digit(input logic [7:0] c);
        return (c >= 8'h30) && (c <= 8'h39);
    endfunction

    // character idx (0..3) of the selected four-letter keyword
    function automatic logic [7:0] kw_char(input kw_e k, input logic [1:0] idx);
        logic [31:0] word;
        word = (k == KW_SAVE) ? "SAVE" : "READ";
        return word[8*(3 - int'(idx)) +: 8];
    endfunction

endpackage

// File: rtl/fcmd_dec_acc.sv
// One decimal step: acc * 10 + digit, with a sticky overflow flag.
module fcmd_dec_acc #(
    parameter int W = 28
) (
    input  logic [W-1:0] acc,
    input  logic         ovf_in,
    input  logic [3:0]   dig,
    output logic [W-1:0] acc_nx,
    output logic         ovf_nx
);
    localparam int WW = W + 4;

    logic [WW-1:0] ext;
    logic [WW-1:0] wide;

    assign ext    = {4'b0000, acc};
    assign wide   = (ext << 3) + (ext << 1) + {{W{1'b0}}, dig};
    assign ovf_nx = ovf_in | (|wide[WW-1:W]);
    assign acc_nx = ovf_nx ? {W{1'b1}} : wide[W-1:0];
endmodule

// File: rtl/fcmd_bin2bcd.sv
// Combinational binary to packed BCD (shift-and-add-three).
module fcmd_bin2bcd #(
    parameter int IN_W   = 28,
    parameter int DIGITS = 9
) (
    input  logic [IN_W-1:0]     bin,
    output logic [4*DIGITS-1:0] bcd
);
    logic [4*DIGITS-1:0] work;

    always_comb begin
        work = '0;
        for (int i = IN_W - 1; i >= 0; i--) begin
            for (int k = 0; k < DIGITS; k++) begin
                if (work[4*k +: 4] >= 4'd5) begin
                    work[4*k +: 4] = work[4*k +: 4] + 4'd3;
                end
            end
            work = {work[4*DIGITS-2:0], bin[i]};
        end
        bcd = work;
    end
endmodule

// File: rtl/fcmd_msg_rom.sv
// Bytes of the error response, in send order.
module fcmd_msg_rom #(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       chr,
    output logic             last
);
    import fcmd_pkg::*;

    localparam int MSG_LEN = 15;

    always_comb begin
        unique case (int'(idx))
            0:       chr = "I";
            1:       chr = "N";
            2:       chr = "V";
            3:       chr = "A";
            4:       chr = "L";
            5:       chr = "I";
            6:       chr = "D";
            7:       chr = CH_SP;
            8:       chr = "D";
            9:       chr = "A";
            10:      chr = "T";
            11:      chr = "A";
            12:      chr = CH_LF;
            13:      chr = CH_CR;
            default: chr = CH_STAR;
        endcase
        last = (int'(idx) >= MSG_LEN - 1);
    end
endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl #(
    parameter int                 FREQ_W     = 28,
    parameter int                 NUM_CH     = 120,
    parameter int                 MAX_DIGITS = 9,
    parameter int                 CH_DIGITS  = 3,
    parameter int unsigned        MIN_HZ     = 1_000_000,
    parameter int unsigned        MAX_HZ     = 130_000_000,
    parameter logic [FREQ_W-1:0]  DEF_FREQ   = 10_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic [FREQ_W-1:0] freq_hz
);
    import fcmd_pkg::*;

    localparam int CH_W      = $clog2(NUM_CH);
    localparam int LINE_W    = $clog2(NUM_CH + 2);
    localparam int CNT_W     = $clog2(MAX_DIGITS + 1);
    localparam int COL_W     = $clog2(CH_DIGITS + MAX_DIGITS + 4);
    localparam int SCALE_W   = 20;
    localparam int WIDE_W    = FREQ_W + SCALE_W;
    localparam int DEF_CR    = MAX_DIGITS;
    localparam int CHL_SP    = CH_DIGITS;
    localparam int CHL_F0    = CH_DIGITS + 1;
    localparam int CHL_CR    = CH_DIGITS + 1 + MAX_DIGITS;
    localparam logic [SCALE_W-1:0] SCALE_1 = SCALE_W'(1);
    localparam logic [SCALE_W-1:0] SCALE_K = SCALE_W'(1000);
    localparam logic [SCALE_W-1:0] SCALE_M = SCALE_W'(1_000_000);

    typedef struct packed {
        top_st_e             st;
        phase_e              ph;
        kw_e                 kw;
        logic [1:0]          kw_idx;
        logic                has_ch;
        logic [CNT_W-1:0]    ndig;
        logic [FREQ_W-1:0]   acc;
        logic                acc_ovf;
        logic [CH_W-1:0]     ch;
        logic                ch_ovf;
        logic [SCALE_W-1:0]  scale;
        logic [FREQ_W-1:0]   cur;
        logic [FREQ_W-1:0]   dflt;
        logic                txv;
        logic [7:0]          txd;
        rsp_e                rsp;
        logic [LINE_W-1:0]   line;
        logic [COL_W-1:0]    col;
    } state_t;

    state_t q, d;
    logic [FREQ_W-1:0] tab_q [NUM_CH];
    logic [FREQ_W-1:0] tab_d [NUM_CH];

    // ---------------- decimal accumulators ----------------
    logic [FREQ_W-1:0] f_acc_nx;
    logic              f_ovf_nx;
    logic [CH_W-1:0]   c_acc_nx;
    logic              c_ovf_nx;

    fcmd_dec_acc #(.W(FREQ_W)) u_facc (
        .acc    (q.acc),
        .ovf_in (q.acc_ovf),
        .dig    (rx_data[3:0]),
        .acc_nx (f_acc_nx),
        .ovf_nx (f_ovf_nx)
    );

    fcmd_dec_acc #(.W(CH_W)) u_cacc (
        .acc    (q.ch),
        .ovf_in (q.ch_ovf),
        .dig    (rx_data[3:0]),
        .acc_nx (c_acc_nx),
        .ovf_nx (c_ovf_nx)
    );

    // ---------------- unit scaling and range test ----------------
    logic [WIDE_W-1:0] scaled;
    logic              freq_ok;
    logic [FREQ_W-1:0] new_freq;

    assign scaled   = {{SCALE_W{1'b0}}, q.acc} * {{FREQ_W{1'b0}}, q.scale};
    assign freq_ok  = !q.acc_ovf && (q.ndig != '0)
                      && (scaled >= WIDE_W'(MIN_HZ)) && (scaled <= WIDE_W'(MAX_HZ));
    assign new_freq = scaled[FREQ_W-1:0];

    // ---------------- response byte generation ----------------
    logic [CH_W-1:0]           ch_idx;
    logic                      line_is_ch;
    logic [FREQ_W-1:0]         sel_val;
    logic [4*MAX_DIGITS-1:0]   f_bcd;
    logic [4*CH_DIGITS-1:0]    c_bcd;
    logic [7:0]                msg_chr;
    logic                      msg_last;
    logic [7:0]                rsp_byte;
    logic                      rsp_last;
    logic                      rsp_eol;

    assign ch_idx     = CH_W'(q.line - LINE_W'(1));
    assign line_is_ch = (q.line != '0) && (int'(q.line) <= NUM_CH);
    assign sel_val    = line_is_ch ? tab_q[ch_idx] : q.dflt;

    fcmd_bin2bcd #(.IN_W(FREQ_W), .DIGITS(MAX_DIGITS)) u_fbcd (
        .bin (sel_val),
        .bcd (f_bcd)
    );

    fcmd_bin2bcd #(.IN_W(CH_W), .DIGITS(CH_DIGITS)) u_cbcd (
        .bin (ch_idx),
        .bcd (c_bcd)
    );

    fcmd_msg_rom #(.IDX_W(COL_W)) u_msg (
        .idx  (q.col),
        .chr  (msg_chr),
        .last (msg_last)
    );

    function automatic logic [7:0] f_digit(input logic [4*MAX_DIGITS-1:0] v, input int pos);
        logic [7:0] r;
        r = "0";
        for (int k = 0; k < MAX_DIGITS; k++) begin
            if (k == pos) r = {4'h3, v[4*(MAX_DIGITS-1-k) +: 4]};
        end
        return r;
    endfunction

    function automatic logic [7:0] c_digit(input logic [4*CH_DIGITS-1:0] v, input int pos);
        logic [7:0] r;
        r = "0";
        for (int k = 0; k < CH_DIGITS; k++) begin
            if (k == pos) r = {4'h3, v[4*(CH_DIGITS-1-k) +: 4]};
        end
        return r;
    endfunction

    always_comb begin
        int c;
        c        = int'(q.col);
        rsp_byte = CH_STAR;
        rsp_last = 1'b0;
        rsp_eol  = 1'b0;
        unique case (q.rsp)
            RSP_OK: begin
                rsp_last = 1'b1;
            end
            RSP_BAD: begin
                rsp_byte = msg_chr;
                rsp_last = msg_last;
            end
            default: begin
                if (q.line == '0) begin
                    if (c < DEF_CR)          rsp_byte = f_digit(f_bcd, c);
                    else if (c == DEF_CR)    rsp_byte = CH_CR;
                    else begin
                        rsp_byte = CH_LF;
                        rsp_eol  = 1'b1;
                    end
                end else if (line_is_ch) begin
                    if (c < CHL_SP)          rsp_byte = c_digit(c_bcd, c);
                    else if (c == CHL_SP)    rsp_byte = CH_SP;
                    else if (c < CHL_CR)     rsp_byte = f_digit(f_bcd, c - CHL_F0);
                    else if (c == CHL_CR)    rsp_byte = CH_CR;
                    else begin
                        rsp_byte = CH_LF;
                        rsp_eol  = 1'b1;
                    end
                end else begin
                    rsp_last = 1'b1;
                end
            end
        endcase
    end

    // ---------------- next-state logic ----------------
    logic slot_free;
    logic rx_take;
    logic rx_dig;

    assign slot_free = !q.txv || tx_ready;
    assign rx_take   = (q.st == ST_RX) && rx_valid && slot_free;
    assign rx_dig    = is_digit(rx_data);

    always_comb begin
        d     = q;
        tab_d = tab_q;

        if (q.txv && tx_ready) d.txv = 1'b0;

        if (rx_take) begin
            d.txv = 1'b1;
            d.txd = rx_data;
            if (rx_data == CH_CR) begin
                d.st   = ST_RESP;
                d.line = '0;
                d.col  = '0;
                d.rsp  = RSP_BAD;
                unique case (q.ph)
                    PH_KWEND: begin
                        if (q.kw == KW_SAVE) begin
                            d.dflt = q.cur;
                            d.rsp  = RSP_OK;
                        end else begin
                            d.rsp  = RSP_READ;
                        end
                    end
                    PH_NUM, PH_UNIT: begin
                        if (freq_ok) begin
                            d.rsp = RSP_OK;
                            if (q.has_ch) tab_d[q.ch] = new_freq;
                            else          d.cur       = new_freq;
                        end
                    end
                    default: ;
                endcase
                d.ph      = PH_START;
                d.kw_idx  = '0;
                d.has_ch  = 1'b0;
                d.ndig    = '0;
                d.acc     = '0;
                d.acc_ovf = 1'b0;
                d.ch      = '0;
                d.ch_ovf  = 1'b0;
                d.scale   = SCALE_1;
            end else begin
                unique case (q.ph)
                    PH_START: begin
                        if (rx_dig) begin
                            d.ph      = PH_NUM;
                            d.acc     = f_acc_nx;
                            d.acc_ovf = f_ovf_nx;
                            d.ndig    = CNT_W'(1);
                            d.has_ch  = 1'b0;
                        end else if (rx_data == "S") begin
                            d.ph     = PH_KW;
                            d.kw     = KW_SAVE;
                            d.kw_idx = 2'd1;
                        end else if (rx_data == "R") begin
                            d.ph     = PH_KW;
                            d.kw     = KW_READ;
                            d.kw_idx = 2'd1;
                        end else begin
                            d.ph = PH_ERR;
                        end
                    end
                    PH_KW: begin
                        if (rx_data == kw_char(q.kw, q.kw_idx)) begin
                            if (q.kw_idx == 2'd3) d.ph     = PH_KWEND;
                            else                  d.kw_idx = q.kw_idx + 2'd1;
                        end else begin
                            d.ph = PH_ERR;
                        end
                    end
                    PH_KWEND: begin
                        if (rx_data == CH_SP && q.kw == KW_SAVE) begin
                            d.ph     = PH_CH;
                            d.ch     = '0;
                            d.ch_ovf = 1'b0;
                            d.ndig   = '0;
                        end else begin
                            d.ph = PH_ERR;
                        end
                    end
                    PH_CH: begin
                        if (rx_dig) begin
                            if (q.ndig == CNT_W'(CH_DIGITS)) begin
                                d.ph = PH_ERR;
                            end else begin
                                d.ch     = c_acc_nx;
                                d.ch_ovf = c_ovf_nx;
                                d.ndig   = q.ndig + CNT_W'(1);
                            end
                        end else if (rx_data == CH_SP && q.ndig != '0
                                     && !q.ch_ovf && int'(q.ch) < NUM_CH) begin
                            d.ph      = PH_NUM;
                            d.has_ch  = 1'b1;
                            d.acc     = '0;
                            d.acc_ovf = 1'b0;
                            d.ndig    = '0;
                            d.scale   = SCALE_1;
                        end else begin
                            d.ph = PH_ERR;
                        end
                    end
                    PH_NUM: begin
                        if (rx_dig) begin
                            if (q.ndig == CNT_W'(MAX_DIGITS)) begin
                                d.ph = PH_ERR;
                            end else begin
                                d.acc     = f_acc_nx;
                                d.acc_ovf = f_ovf_nx;
                                d.ndig    = q.ndig + CNT_W'(1);
                            end
                        end else if (rx_data == "K" && q.ndig != '0) begin
                            d.ph    = PH_UNIT;
                            d.scale = SCALE_K;
                        end else if (rx_data == "M" && q.ndig != '0) begin
                            d.ph    = PH_UNIT;
                            d.scale = SCALE_M;
                        end else begin
                            d.ph = PH_ERR;
                        end
                    end
                    default: d.ph = PH_ERR;
                endcase
            end
        end

        if (q.st == ST_RESP && slot_free) begin
            d.txv = 1'b1;
            d.txd = rsp_byte;
            if (rsp_last) begin
                d.st = ST_RX;
            end else if (rsp_eol) begin
                d.line = q.line + LINE_W'(1);
                d.col  = '0;
            end else begin
                d.col = q.col + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.cur   <= DEF_FREQ;
            q.dflt  <= DEF_FREQ;
            q.scale <= SCALE_1;
            for (int i = 0; i < NUM_CH; i++) tab_q[i] <= '0;
        end else begin
            q     <= d;
            tab_q <= tab_d;
        end
    end

    assign tx_valid = q.txv;
    assign tx_data  = q.txd;
    assign freq_hz  = q.cur;

endmodule

// File: rtl/fcmd_ctrl_chk.sv
module fcmd_ctrl_chk #(
    parameter int          FREQ_W = 28,
    parameter int unsigned MIN_HZ = 1_000_000,
    parameter int unsigned MAX_HZ = 130_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic [7:0]        rx_data,
    input logic              tx_ready,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic [FREQ_W-1:0] freq_hz
);
    // R9
    tx_valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid);

    // R9
    tx_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> $stable(tx_data));

    // R5
    freq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (64'(freq_hz) >= 64'(MIN_HZ)) && (64'(freq_hz) <= 64'(MAX_HZ)));

    // R11
    freq_on_cr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_data == 8'h0D) |=> $stable(freq_hz));
endmodule

bind fcmd_ctrl fcmd_ctrl_chk #(
    .FREQ_W (FREQ_W),
    .MIN_HZ (MIN_HZ),
    .MAX_HZ (MAX_HZ)
) u_fcmd_ctrl_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .freq_hz  (freq_hz)
);

// File: tb/test_fcmd_ctrl.sv
module test_fcmd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 120;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        tx_ready = 1'b1;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic [27:0] freq_hz;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcmd_ctrl i_fcmd_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .freq_hz  (freq_hz)
    );

    logic [7:0]  exp_q[$];
    logic [7:0]  mon_exp;
    string       tag = "R1";
    int          n_chk = 0;
    int          n_fail = 0;
    bit          bp_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int unsigned m_cur = 10_000_000;
    int unsigned m_def = 10_000_000;
    int unsigned m_tab [NUM_CH];
    string       bad_txt;

    // monitor: pops expected bytes as the design hands them over
    always @(negedge clk) begin
        if (bp_en) begin
            lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tx_ready = lfsr[0] | lfsr[3];
        end else begin
            tx_ready = 1'b1;
        end
        #1;
        if (rst_n && tx_valid && tx_ready) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL %s: tx byte %02h, expected none", tag, tx_data);
            end else begin
                mon_exp = exp_q.pop_front();
                if (tx_data !== mon_exp) begin
                    n_fail++;
                    $display("FAIL %s: tx byte %02h, expected %02h", tag, tx_data, mon_exp);
                end
            end
        end
    end

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
        $finish;
    end

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        rx_data  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic push_str(input string s);
        for (int i = 0; i < s.len(); i++) exp_q.push_back(s[i]);
    endtask

    task automatic type_chars(input string s);
        for (int i = 0; i < s.len(); i++) begin
            exp_q.push_back(s[i]);
            put_byte(s[i]);
            drain();
        end
    endtask

    task automatic send_cmd(input string s, input string resp);
        type_chars(s);
        exp_q.push_back(8'h0D);
        push_str(resp);
        put_byte(8'h0D);
        drain();
    endtask

    task automatic check_freq(input string r);
        n_chk++;
        if (freq_hz !== m_cur[27:0]) begin
            n_fail++;
            $display("FAIL %s: freq_hz %0d, expected %0d", r, freq_hz, m_cur);
        end
    endtask

    task automatic cmd_set(input string s, input int unsigned hz, input bit ok, input string r);
        tag = r;
        send_cmd(s, ok ? "*" : bad_txt);
        if (ok) m_cur = hz;
        check_freq(r);
    endtask

    task automatic cmd_save_ch(input string s, input int ch, input int unsigned hz,
                               input bit ok, input string r);
        tag = r;
        send_cmd(s, ok ? "*" : bad_txt);
        if (ok) m_tab[ch] = hz;
        check_freq(r);
    endtask

    function automatic string dump_txt();
        string s;
        s = $sformatf("%09d%c%c", m_def, 8'h0D, 8'h0A);
        for (int ch = 0; ch < NUM_CH; ch++) begin
            s = {s, $sformatf("%03d %09d%c%c", ch, m_tab[ch], 8'h0D, 8'h0A)};
        end
        s = {s, "*"};
        return s;
    endfunction

    initial begin
        for (int i = 0; i < NUM_CH; i++) m_tab[i] = 0;
        bad_txt = $sformatf("INVALID DATA%c%c*", 8'h0A, 8'h0D);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports
        tag = "R1";
        check_freq("R1");
        n_chk++;
        if (tx_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: tx_valid %0b, expected 0", tx_valid);
        end

        // R1 / R8: dump after reset shows default and empty table
        tag = "R8";
        send_cmd("READ", dump_txt());

        // R2: echo then prompt
        cmd_set("88M", 88_000_000, 1'b1, "R2");

        // R3: plain hertz, nine digits, ten digits
        cmd_set("123456789", 123_456_789, 1'b1, "R3");
        cmd_set("1234567890", 0, 1'b0, "R3");

        // R4: unit suffixes
        cmd_set("2500K", 2_500_000, 1'b1, "R4");
        cmd_set("125M", 125_000_000, 1'b1, "R4");

        // R5: range boundaries and malformed lines
        cmd_set("130M", 130_000_000, 1'b1, "R5");
        cmd_set("131M", 0, 1'b0, "R5");
        cmd_set("130000001", 0, 1'b0, "R5");
        cmd_set("1000000", 1_000_000, 1'b1, "R5");
        cmd_set("999999", 0, 1'b0, "R5");
        cmd_set("45K", 0, 1'b0, "R5");
        cmd_set("12m", 0, 1'b0, "R5");
        cmd_set("", 0, 1'b0, "R5");
        cmd_set("M", 0, 1'b0, "R5");
        cmd_set("READX", 0, 1'b0, "R5");
        cmd_set("5MX", 0, 1'b0, "R5");
        cmd_set("save", 0, 1'b0, "R5");

        // R11: frequency holds until the carriage return
        tag = "R11";
        type_chars("77M");
        check_freq("R11");
        exp_q.push_back(8'h0D);
        push_str("*");
        put_byte(8'h0D);
        drain();
        m_cur = 77_000_000;
        check_freq("R11");

        // R6: save current into default
        tag = "R6";
        send_cmd("SAVE", "*");
        m_def = m_cur;
        check_freq("R6");

        // R7: indexed channel save
        cmd_save_ch("SAVE 0 123M", 0, 123_000_000, 1'b1, "R7");
        cmd_save_ch("SAVE 119 123456K", 119, 123_456_000, 1'b1, "R7");
        cmd_save_ch("SAVE 5 2000000", 5, 2_000_000, 1'b1, "R7");
        cmd_save_ch("SAVE 120 5M", 0, 0, 1'b0, "R7");
        cmd_save_ch("SAVE 7 50", 0, 0, 1'b0, "R7");
        cmd_save_ch("SAVE 12", 0, 0, 1'b0, "R7");
        cmd_save_ch("SAVE 0012 5M", 0, 0, 1'b0, "R7");

        // R8 / R9: full dump under irregular back-pressure
        tag = "R9";
        bp_en = 1'b1;
        send_cmd("READ", dump_txt());
        bp_en = 1'b0;
        @(negedge clk);

        // R10: bytes sent during a dump are dropped
        tag = "R10";
        type_chars("READ");
        exp_q.push_back(8'h0D);
        push_str(dump_txt());
        put_byte(8'h0D);
        repeat (200) @(negedge clk);
        put_byte("5");
        put_byte("M");
        put_byte(8'h0D);
        drain();
        check_freq("R10");
        cmd_set("20M", 20_000_000, 1'b1, "R10");

        summary();
        $finish;
    end
endmodule